// File: doc/BRIEF.md
# Segment Descriptor Cache

This block keeps recently used segment translation entries for a virtual memory unit whose address space is split into four sections. Each section owns eight direct-mapped slots, so the cache holds 32 entries in all. An entry is two 32-bit words. The low word carries the access byte, the maximum-offset field and an address tag. The high word carries the segment base, four descriptor flags and a Good bit that marks the slot as usable.

A translation engine presents a virtual address on the lookup port. In the same cycle it gets back a hit indication, the decoded fields and a rebuilt pair of descriptor words. After a table walk, the engine hands the raw two-word descriptor to the fill port. The block repacks it and stores it, but only if the descriptor is usable and fault recording is on for the access. Both arrays can also be read and written directly, one word at a time, through a register-style port. Walking the tables and checking permissions happen outside this block.

Top module: `seg_desc_cache`

## Requirements
- R1: An entry is chosen by the virtual address. The section is address bits 31:30 and the slot within the section is bits 19:17. On the register port the 5-bit entry number is {section, slot}, with the section in the upper two bits.
- R2: A fill writes the low word as descriptor word 0 bits 31:10 in bits 31:10, with virtual address bits 29:20 as the tag in bits 9:0.
- R3: A fill writes the high word as descriptor word 1 bits 31:5 in bits 31:5, descriptor word 0 bits 4:1 in bits 4:1, and 1 in bit 0 (the Good bit).
- R4: A fill changes the cache only when fill_rec is 1 and descriptor word 0 has both bit 6 (valid) and bit 0 (present) set. Any other fill leaves every entry unchanged.
- R5: lk_hit is 1 exactly when the selected entry has its Good bit set and its stored tag equals lookup address bits 29:20. On a hit, lk_acc = low[31:24], lk_maxoff = low[23:10] and lk_flags = high[4:1]. On a miss these outputs are 0.
- R6: On a hit, lk_sd0 is rebuilt as low[31:10] in bits 31:10, zeros in bits 9:7 and bit 5, 1 in bits 6 and 0, and high[4:1] in bits 4:1. lk_sd1 is high[31:5] with bits 4:0 cleared. On a miss both are 0.
- R7: A fill takes effect at the clock edge that samples it. A lookup made in the same cycle returns the old contents. A later fill to the same entry replaces it.
- R8: Reset clears both words of every entry. After reset, every lookup misses and every register read returns 0.
- R9: A register write stores reg_wdata into the low word (reg_hi=0) or the high word (reg_hi=1) of entry reg_addr at the clock edge. reg_rdata shows that word combinationally. Lookups use words written this way in the same manner as filled ones.
- R10: When a fill and a register write target the same entry in one cycle, the fill sets both words and the register write is dropped. When they target different entries, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_acc | output | 8 | Access byte of hit entry |
| lk_maxoff | output | 14 | Maximum-offset field of hit entry |
| lk_flags | output | 4 | Trap, cacheable, contiguous, modified flags (bits 3..0) |
| lk_sd0 | output | 32 | Rebuilt descriptor word 0 |
| lk_sd1 | output | 32 | Rebuilt descriptor word 1 |
| fill_en | input | 1 | Fill request |
| fill_rec | input | 1 | Fault recording enabled for this access |
| fill_va | input | 32 | Virtual address of the filled descriptor |
| fill_sd0 | input | 32 | Raw descriptor word 0 |
| fill_sd1 | input | 32 | Raw descriptor word 1 |
| reg_we | input | 1 | Register write strobe |
| reg_hi | input | 1 | Selects the high (1) or low (0) word |
| reg_addr | input | 5 | Entry number {section, slot} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The lookup path has no register stage, so a wrong stored word shows up on lk_hit and the field outputs in the first cycle after the faulty write. It is also visible straight away on reg_rdata for that entry. A wrong slot or section decode shows as a hit on a neighbouring address or as a miss after a fill. A wrong repacking shows as a mismatch in lk_sd0, lk_sd1 or the raw words read back. A Good bit left set through reset shows as a hit on the first lookup.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int WORD_W      = 32;
  localparam int TAG_FIELD_W = 10;
  localparam int ACC_W       = 8;
  localparam int MOFF_W      = 14;
  localparam int FLAG_W      = 4;

  localparam int D0_PRESENT  = 0;
  localparam int D0_VALID    = 6;

  function automatic logic [WORD_W-1:0] sdc_pack_low(
    input logic [WORD_W-1:0]      sd0,
    input logic [TAG_FIELD_W-1:0] tag
  );
    return {sd0[31:10], tag};
  endfunction

  function automatic logic [WORD_W-1:0] sdc_pack_high(
    input logic [WORD_W-1:0] sd0,
    input logic [WORD_W-1:0] sd1
  );
    return {sd1[31:5], sd0[4:1], 1'b1};
  endfunction

  function automatic logic sdc_cacheable(
    input logic [WORD_W-1:0] sd0,
    input logic              rec
  );
    return rec & sd0[D0_VALID] & sd0[D0_PRESENT];
  endfunction

  function automatic logic [WORD_W-1:0] sdc_rebuild_sd0(
    input logic [WORD_W-1:0] lo,
    input logic [WORD_W-1:0] hi
  );
    return {lo[31:10], 3'b000, 1'b1, 1'b0, hi[4:1], 1'b1};
  endfunction

  function automatic logic [WORD_W-1:0] sdc_rebuild_sd1(
    input logic [WORD_W-1:0] hi
  );
    return {hi[31:5], 5'b00000};
  endfunction

  function automatic logic [TAG_FIELD_W-1:0] sdc_low_tag(
    input logic [WORD_W-1:0] lo
  );
    return lo[TAG_FIELD_W-1:0];
  endfunction

endpackage

// File: rtl/sdc_addr_decode.sv
module sdc_addr_decode
  import sdc_pkg::*;
#(
  parameter int SEC_W = 2,
  parameter int IDX_W = 3,
  localparam int ENT_W = SEC_W + IDX_W,
  localparam int TAG_W = 30 - 17 - IDX_W
) (
  input  logic [WORD_W-1:0]      va,
  output logic [ENT_W-1:0]       ent,
  output logic [TAG_FIELD_W-1:0] tag
);

  logic [SEC_W-1:0] sec;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] raw_tag;

  always_comb begin
    sec     = va[WORD_W-1 -: SEC_W];
    idx     = va[17 +: IDX_W];
    raw_tag = va[29 -: TAG_W];
    ent     = {sec, idx};
    tag     = TAG_FIELD_W'(raw_tag);
  end

endmodule

// File: rtl/sdc_fill_conv.sv
module sdc_fill_conv
  import sdc_pkg::*;
#(
  parameter int SEC_W = 2,
  parameter int IDX_W = 3,
  localparam int ENT_W = SEC_W + IDX_W
) (
  input  logic              fill_en,
  input  logic              fill_rec,
  input  logic [WORD_W-1:0] fill_va,
  input  logic [WORD_W-1:0] fill_sd0,
  input  logic [WORD_W-1:0] fill_sd1,
  output logic              wr_en,
  output logic [ENT_W-1:0]  wr_ent,
  output logic [WORD_W-1:0] wr_low,
  output logic [WORD_W-1:0] wr_high
);

  logic [TAG_FIELD_W-1:0] fill_tag;

  sdc_addr_decode #(.SEC_W(SEC_W), .IDX_W(IDX_W)) u_dec (
    .va  (fill_va),
    .ent (wr_ent),
    .tag (fill_tag)
  );

  always_comb begin
    wr_en   = fill_en & sdc_cacheable(fill_sd0, fill_rec);
    wr_low  = sdc_pack_low(fill_sd0, fill_tag);
    wr_high = sdc_pack_high(fill_sd0, fill_sd1);
  end

endmodule

// File: rtl/sdc_store.sv
module sdc_store
  import sdc_pkg::*;
#(
  parameter int SEC_W = 2,
  parameter int IDX_W = 3,
  localparam int ENT_W = SEC_W + IDX_W,
  localparam int N_ENT = 1 << ENT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [ENT_W-1:0]  fill_ent,
  input  logic [WORD_W-1:0] fill_low,
  input  logic [WORD_W-1:0] fill_high,
  input  logic              reg_we,
  input  logic              reg_hi,
  input  logic [ENT_W-1:0]  reg_ent,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [ENT_W-1:0]  rd_ent_a,
  output logic [WORD_W-1:0] rd_low_a,
  output logic [WORD_W-1:0] rd_high_a,
  input  logic [ENT_W-1:0]  rd_ent_b,
  output logic [WORD_W-1:0] rd_low_b,
  output logic [WORD_W-1:0] rd_high_b
);

  logic [WORD_W-1:0] lo_arr [N_ENT];
  logic [WORD_W-1:0] hi_arr [N_ENT];
  logic [N_ENT-1:0]  good_vec;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [WORD_W-1:0] lo_r;
    logic [WORD_W-1:0] hi_r;
    logic              fill_sel;
    logic              reg_sel;

    assign fill_sel = fill_we && (fill_ent == ENT_W'(e));
    assign reg_sel  = reg_we  && (reg_ent  == ENT_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_r <= '0;
        hi_r <= '0;
      end else if (fill_sel) begin
        lo_r <= fill_low;
        hi_r <= fill_high;
      end else if (reg_sel) begin
        if (reg_hi) hi_r <= reg_wdata;
        else        lo_r <= reg_wdata;
      end
    end

    assign lo_arr[e] = lo_r;
    assign hi_arr[e] = hi_r;
  end

  always_comb begin
    for (int e = 0; e < N_ENT; e++) good_vec[e] = hi_arr[e][0];
    rd_low_a  = lo_arr[rd_ent_a];
    rd_high_a = hi_arr[rd_ent_a];
    rd_low_b  = lo_arr[rd_ent_b];
    rd_high_b = hi_arr[rd_ent_b];
  end

  AST_FILL_SETS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> hi_arr[$past(fill_ent)][0]); // R3

  AST_FILL_BEATS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && reg_we && fill_ent == reg_ent) |=>
      (lo_arr[$past(fill_ent)] == $past(fill_low))); // R10

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_we && !reg_we) |=> $stable(good_vec)); // R4

endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import sdc_pkg::*;
#(
  parameter int SEC_W = 2,
  parameter int IDX_W = 3,
  localparam int ENT_W = SEC_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_va,
  output logic              lk_hit,
  output logic [7:0]        lk_acc,
  output logic [13:0]       lk_maxoff,
  output logic [3:0]        lk_flags,
  output logic [31:0]       lk_sd0,
  output logic [31:0]       lk_sd1,
  input  logic              fill_en,
  input  logic              fill_rec,
  input  logic [31:0]       fill_va,
  input  logic [31:0]       fill_sd0,
  input  logic [31:0]       fill_sd1,
  input  logic              reg_we,
  input  logic              reg_hi,
  input  logic [ENT_W-1:0]  reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  logic [ENT_W-1:0]       lk_ent;
  logic [TAG_FIELD_W-1:0] lk_tag;
  logic                   fill_we;
  logic [ENT_W-1:0]       fill_ent;
  logic [WORD_W-1:0]      fill_low;
  logic [WORD_W-1:0]      fill_high;
  logic [WORD_W-1:0]      lk_lo;
  logic [WORD_W-1:0]      lk_hi;
  logic [WORD_W-1:0]      rg_lo;
  logic [WORD_W-1:0]      rg_hi;
  logic                   lk_good;
  logic                   lk_tag_eq;

  sdc_addr_decode #(.SEC_W(SEC_W), .IDX_W(IDX_W)) u_lk_dec (
    .va  (lk_va),
    .ent (lk_ent),
    .tag (lk_tag)
  );

  sdc_fill_conv #(.SEC_W(SEC_W), .IDX_W(IDX_W)) u_conv (
    .fill_en  (fill_en),
    .fill_rec (fill_rec),
    .fill_va  (fill_va),
    .fill_sd0 (fill_sd0),
    .fill_sd1 (fill_sd1),
    .wr_en    (fill_we),
    .wr_ent   (fill_ent),
    .wr_low   (fill_low),
    .wr_high  (fill_high)
  );

  sdc_store #(.SEC_W(SEC_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_we   (fill_we),
    .fill_ent  (fill_ent),
    .fill_low  (fill_low),
    .fill_high (fill_high),
    .reg_we    (reg_we),
    .reg_hi    (reg_hi),
    .reg_ent   (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_ent_a  (lk_ent),
    .rd_low_a  (lk_lo),
    .rd_high_a (lk_hi),
    .rd_ent_b  (reg_addr),
    .rd_low_b  (rg_lo),
    .rd_high_b (rg_hi)
  );

  always_comb begin
    lk_good   = lk_hi[0];
    lk_tag_eq = (sdc_low_tag(lk_lo) == lk_tag);
    lk_hit    = lk_good & lk_tag_eq;
    if (lk_hit) begin
      lk_acc    = lk_lo[31:24];
      lk_maxoff = lk_lo[23:10];
      lk_flags  = lk_hi[4:1];
      lk_sd0    = sdc_rebuild_sd0(lk_lo, lk_hi);
      lk_sd1    = sdc_rebuild_sd1(lk_hi);
    end else begin
      lk_acc    = '0;
      lk_maxoff = '0;
      lk_flags  = '0;
      lk_sd0    = '0;
      lk_sd1    = '0;
    end
    reg_rdata = reg_hi ? rg_hi : rg_lo;
  end

  AST_HIT_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_hi[0]); // R5

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_acc == 8'd0 && lk_maxoff == 14'd0 && lk_sd1 == 32'd0)); // R5

  AST_REBUILD_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_sd0[6] && lk_sd0[0] && lk_sd1[4:0] == 5'd0)); // R6

  AST_INELIGIBLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && (!fill_rec || !fill_sd0[6] || !fill_sd0[0])) |-> !fill_we); // R4

  AST_FILL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> (fill_ent == {fill_va[31:30], fill_va[19:17]})); // R1

endmodule

// File: tb/sim_seg_desc_cache.sv
`timescale 1ns/1ps
module sim_seg_desc_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [7:0]  lk_acc;
  logic [13:0] lk_maxoff;
  logic [3:0]  lk_flags;
  logic [31:0] lk_sd0, lk_sd1;
  logic        fill_en = 1'b0, fill_rec = 1'b0;
  logic [31:0] fill_va = '0, fill_sd0 = '0, fill_sd1 = '0;
  logic        reg_we = 1'b0, reg_hi = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #5 clk = ~clk;

  seg_desc_cache u0 (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_acc(lk_acc),
    .lk_maxoff(lk_maxoff), .lk_flags(lk_flags), .lk_sd0(lk_sd0), .lk_sd1(lk_sd1),
    .fill_en(fill_en), .fill_rec(fill_rec), .fill_va(fill_va), .fill_sd0(fill_sd0),
    .fill_sd1(fill_sd1), .reg_we(reg_we), .reg_hi(reg_hi), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct {
    bit          is_reg;
    string       req;
    logic        hit;
    logic [7:0]  acc;
    logic [13:0] moff;
    logic [3:0]  flags;
    logic [31:0] sd0;
    logic [31:0] sd1;
    logic [31:0] rdata;
  } exp_t;

  exp_t  sb[$];
  event  sample_ev;
  int    n_run = 0;
  int    n_fail = 0;

  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];

  function automatic logic [31:0] mkva(int sec, int tag, int slot, int off);
    logic [31:0] v;
    v = 32'(off) & 32'h1FFFF;
    v[31:30] = 2'(sec);
    v[29:20] = 10'(tag);
    v[19:17] = 3'(slot);
    return v;
  endfunction

  function automatic int ent_of(logic [31:0] va);
    return int'(va[31:30]) * 8 + int'(va[19:17]);
  endfunction

  function automatic exp_t predict(logic [31:0] va, string req);
    exp_t x;
    int e;
    e = ent_of(va);
    x.is_reg = 0;
    x.req = req;
    x.hit = m_hi[e][0] && (m_lo[e][9:0] == va[29:20]);
    x.acc = x.hit ? m_lo[e][31:24] : 8'h0;
    x.moff = x.hit ? m_lo[e][23:10] : 14'h0;
    x.flags = x.hit ? m_hi[e][4:1] : 4'h0;
    x.sd0 = '0;
    if (x.hit) begin
      x.sd0[31:10] = m_lo[e][31:10];
      x.sd0[6] = 1'b1;
      x.sd0[4:1] = m_hi[e][4:1];
      x.sd0[0] = 1'b1;
    end
    x.sd1 = x.hit ? (m_hi[e] & 32'hFFFF_FFE0) : 32'h0;
    x.rdata = '0;
    return x;
  endfunction

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        n_run++;
        if (x.is_reg) begin
          if (reg_rdata !== x.rdata) begin
            n_fail++;
            $display("FAIL %s reg_rdata got %h exp %h", x.req, reg_rdata, x.rdata);
          end
        end else if (lk_hit !== x.hit || lk_acc !== x.acc || lk_maxoff !== x.moff ||
                     lk_flags !== x.flags || lk_sd0 !== x.sd0 || lk_sd1 !== x.sd1) begin
          n_fail++;
          $display("FAIL %s lookup got hit=%b acc=%h moff=%h fl=%h sd0=%h sd1=%h exp hit=%b acc=%h moff=%h fl=%h sd0=%h sd1=%h",
                   x.req, lk_hit, lk_acc, lk_maxoff, lk_flags, lk_sd0, lk_sd1,
                   x.hit, x.acc, x.moff, x.flags, x.sd0, x.sd1);
        end
      end
    end
  end

  task automatic check_lookup(logic [31:0] va, string req);
    @(negedge clk);
    lk_va = va;
    #1;
    sb.push_back(predict(va, req));
    -> sample_ev;
  endtask

  task automatic check_reg(int e, bit hi, string req);
    exp_t x;
    @(negedge clk);
    reg_addr = 5'(e);
    reg_hi = hi;
    #1;
    x = predict(32'h0, req);
    x.is_reg = 1;
    x.rdata = hi ? m_hi[e] : m_lo[e];
    sb.push_back(x);
    -> sample_ev;
  endtask

  function automatic void model_fill(logic [31:0] va, logic [31:0] s0, logic [31:0] s1, bit rec);
    int e;
    if (rec && s0[6] && s0[0]) begin
      e = ent_of(va);
      m_lo[e] = {s0[31:10], va[29:20]};
      m_hi[e] = {s1[31:5], s0[4:1], 1'b1};
    end
  endfunction

  task automatic do_fill(logic [31:0] va, logic [31:0] s0, logic [31:0] s1, bit rec);
    @(negedge clk);
    fill_en = 1'b1; fill_rec = rec; fill_va = va; fill_sd0 = s0; fill_sd1 = s1;
    @(negedge clk);
    fill_en = 1'b0;
    model_fill(va, s0, s1, rec);
  endtask

  task automatic do_reg_wr(int e, bit hi, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(e); reg_hi = hi; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (hi) m_hi[e] = d; else m_lo[e] = d;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] va_a, va_b, va_c, va_d;
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    check_lookup(mkva(0, 0, 0, 0), "R8 reset miss");
    check_lookup(mkva(2, 10'h155, 6, 5), "R8 reset miss tag");
    check_reg(11, 0, "R8 reset low");
    check_reg(11, 1, "R8 reset high");

    // R2 R3 R5 R6: eligible fill then hit
    va_a = mkva(1, 10'h2A5, 3, 17'h1ABCD);
    do_fill(va_a, 32'h9E48_C0FF, 32'h1234_567F, 1'b1);
    check_lookup(va_a, "R5 hit fields");
    check_lookup(mkva(1, 10'h2A5, 3, 0), "R6 rebuild any offset");
    check_reg(11, 0, "R2 low word packing");
    check_reg(11, 1, "R3 high word packing");

    // R1 R5: tag, section and slot selection
    check_lookup(mkva(1, 10'h2A4, 3, 0), "R5 tag mismatch miss");
    check_lookup(mkva(2, 10'h2A5, 3, 0), "R1 other section miss");
    check_lookup(mkva(1, 10'h2A5, 4, 0), "R1 other slot miss");

    // R4: ineligible fills
    va_b = mkva(3, 10'h011, 7, 0);
    do_fill(va_b, 32'h7700_04BF, 32'hABCD_0000, 1'b1);
    check_lookup(va_b, "R4 invalid bit clear");
    do_fill(va_b, 32'h7700_04FE, 32'hABCD_0000, 1'b1);
    check_lookup(va_b, "R4 present bit clear");
    do_fill(va_b, 32'h7700_04FF, 32'hABCD_0000, 1'b0);
    check_lookup(va_b, "R4 recording off");
    check_reg(31, 1, "R4 high untouched");
    do_fill(va_b, 32'h7700_0441, 32'hABCD_001F, 1'b1);
    check_lookup(va_b, "R4 minimal eligible");

    // R7: same-cycle lookup sees old contents
    va_c = mkva(0, 10'h3FF, 5, 0);
    @(negedge clk);
    fill_en = 1'b1; fill_rec = 1'b1; fill_va = va_c;
    fill_sd0 = 32'h5A3C_2F5B; fill_sd1 = 32'hFEDC_BA9F;
    lk_va = va_c;
    #1;
    sb.push_back(predict(va_c, "R7 same cycle old"));
    -> sample_ev;
    @(negedge clk);
    fill_en = 1'b0;
    model_fill(va_c, 32'h5A3C_2F5B, 32'hFEDC_BA9F, 1'b1);
    #1;
    sb.push_back(predict(va_c, "R7 next cycle new"));
    -> sample_ev;
    do_fill(mkva(0, 10'h001, 5, 0), 32'h0102_0443, 32'h8000_0000, 1'b1);
    check_lookup(va_c, "R7 overwrite evicts");
    check_lookup(mkva(0, 10'h001, 5, 0), "R7 overwrite hit");

    // R9: register writes feed lookups
    do_reg_wr(18, 0, {8'hC4, 14'h2222, 10'h0F0});
    do_reg_wr(18, 1, 32'h4444_4015);
    va_d = mkva(2, 10'h0F0, 2, 0);
    check_lookup(va_d, "R9 reg written hit");
    check_reg(18, 0, "R9 read low");
    check_reg(18, 1, "R9 read high");
    do_reg_wr(18, 1, 32'h4444_4014);
    check_lookup(va_d, "R9 good cleared miss");

    // R10: fill vs register write collision
    @(negedge clk);
    fill_en = 1'b1; fill_rec = 1'b1; fill_va = va_d;
    fill_sd0 = 32'h3300_8847; fill_sd1 = 32'h0BAD_F000;
    reg_we = 1'b1; reg_addr = 5'd18; reg_hi = 1'b0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    fill_en = 1'b0; reg_we = 1'b0;
    model_fill(va_d, 32'h3300_8847, 32'h0BAD_F000, 1'b1);
    check_lookup(va_d, "R10 fill wins");
    check_reg(18, 0, "R10 low from fill");
    @(negedge clk);
    fill_en = 1'b1; fill_rec = 1'b1; fill_va = va_a;
    fill_sd0 = 32'h1111_1141; fill_sd1 = 32'h2222_2220;
    reg_we = 1'b1; reg_addr = 5'd31; reg_hi = 1'b0; reg_wdata = 32'h0000_0011;
    @(negedge clk);
    fill_en = 1'b0; reg_we = 1'b0;
    model_fill(va_a, 32'h1111_1141, 32'h2222_2220, 1'b1);
    m_lo[31] = 32'h0000_0011;
    check_lookup(va_a, "R10 distinct fill");
    check_reg(31, 0, "R10 distinct reg");
    check_lookup(va_b, "R10 distinct reg lookup");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule